// File: doc/BRIEF.md
# Three-Press Combination Lock Sequencer

This block is the decision core of a push-button combination lock. It watches four button levels, one per digit from 0 to 3, and turns each new press into one step of a three-digit entry. The secret sequence is digit 0, then digit 2, then digit 3. After the third press it raises one of two result bits: one for a correct code and one for a wrong code. During entry both bits stay low.

The buttons are assumed to be debounced already. A press counts on the rising edge of a button level, so holding a button down advances the entry by only one step. A wrong digit does not end the entry early. The machine always collects all three presses before it gives a verdict. The verdict then stays on the outputs until the next press. That press clears the outputs and counts as the first digit of a new entry.

An active-low clear returns the block to the idle state from any state. The outputs come from registers and depend only on the state.

Top module: `combo_lock`

## Requirements
- R1: While `clr_ni` is low, and after it is released, `verdict_o` is 2'b00 and the next press is taken as the first digit.
- R2: A press is a 0-to-1 transition of a bit of `key_i`, where bit n stands for digit n. Holding a key high for any number of cycles counts as one press.
- R3: Pressing digit 0, then digit 2, then digit 3 sets `verdict_o` to 2'b01 (bit 0 = open). The change takes effect at the same clock edge that first samples the third key high.
- R4: If three presses have been made and at least one of them did not match its position in the code, `verdict_o` becomes 2'b10 (bit 1 = error) at that third press edge.
- R5: After the first and after the second press of an entry, `verdict_o` is 2'b00, whether those digits matched or not.
- R6: Two or more bits of `key_i` rising in the same cycle count as a single press that does not match.
- R7: A verdict holds while no key rises. The next press clears `verdict_o` to 2'b00 and is taken as the first digit of a new entry.
- R8: A key that is already high when `clr_ni` is released does not count as a press until it has gone low and risen again.
- R9: `verdict_o` never has both bits high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (100 MHz in the target system) |
| clr_ni | input | 1 | Asynchronous clear, active low |
| key_i | input | 4 | Debounced key levels; bit n is digit n |
| verdict_o | output | 2 | Registered result: bit 0 = code correct, bit 1 = code wrong |

## Verification
Two functions can fall in the same cycle:
- **Verdict clearing and the first digit.** The press that clears a displayed verdict is also the first digit of the next entry. The bench provokes this by starting a new entry directly after a verdict, with no idle gap. It judges the case by whether the follow-up presses end in the verdict the reference model predicts.
- **Several keys rising at once.** More than one key can rise in one sampling cycle. The bench drives multi-key vectors, both directed and random, at the first position and mid-entry. The model counts each such vector as one mismatching press, which checks both the press count and the final error verdict.

A key held through the release of clear is also exercised. This separates a press that is really new from a level that was already present at reset.

// File: rtl/lock_pkg.sv
package lock_pkg;

    // Result encoding on the verdict output
    typedef enum logic [1:0] {
        VERD_NONE = 2'b00,
        VERD_OPEN = 2'b01,
        VERD_ERR  = 2'b10
    } verdict_e;

    // Phase of the entry sequencer
    typedef enum logic {
        PH_COLLECT = 1'b0,
        PH_SHOW    = 1'b1
    } phase_e;

    localparam int unsigned DEF_NUM_KEYS = 4;
    localparam int unsigned DEF_CODE_LEN = 3;
    localparam int unsigned DEF_KEY_W    = 2;

    // Digit for position p sits at [p*KEY_W +: KEY_W]; position 0 is entered first
    localparam logic [DEF_CODE_LEN*DEF_KEY_W-1:0] DEF_CODE = {2'd3, 2'd2, 2'd0};

endpackage

// File: rtl/lock_edge_detect.sv
module lock_edge_detect #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             clr_ni,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] prev_d;
    logic [WIDTH-1:0] prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    // Reset to all ones: a level held through clear must fall before it counts
    always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) begin
            prev_q <= '1;
        end else begin
            prev_q <= prev_d;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_rise
            assign rise_o[gi] = lvl_i[gi] & ~prev_q[gi];
        end
    endgenerate

endmodule

// File: rtl/lock_key_decode.sv
module lock_key_decode #(
    parameter int unsigned NUM_KEYS = 4,
    parameter int unsigned KEY_W    = 2
) (
    input  logic [NUM_KEYS-1:0] rise_i,
    output logic                press_o,
    output logic                single_o,
    output logic [KEY_W-1:0]    digit_o
);

    localparam int unsigned CNT_W = $clog2(NUM_KEYS + 1);

    logic [CNT_W-1:0] n_rise;
    logic [KEY_W-1:0] enc;

    always_comb begin
        n_rise = '0;
        enc    = '0;
        for (int i = 0; i < NUM_KEYS; i++) begin
            if (rise_i[i]) begin
                n_rise = n_rise + CNT_W'(1);
                enc    = enc | KEY_W'(i);
            end
        end
    end

    assign press_o  = (n_rise != '0);
    assign single_o = (n_rise == CNT_W'(1));
    assign digit_o  = enc;

endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
    import lock_pkg::*;
#(
    parameter int unsigned                      CODE_LEN = DEF_CODE_LEN,
    parameter int unsigned                      KEY_W    = DEF_KEY_W,
    parameter logic [CODE_LEN*KEY_W-1:0]        CODE     = DEF_CODE
) (
    input  logic             clk_i,
    input  logic             clr_ni,
    input  logic             press_i,
    input  logic             single_i,
    input  logic [KEY_W-1:0] digit_i,
    output logic [1:0]       verdict_o
);

    localparam int unsigned   IDX_W    = $clog2(CODE_LEN + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_LEN - 1);

    typedef struct packed {
        phase_e     phase;
        logic [IDX_W-1:0] idx;
        logic       ok;
        verdict_e   verdict;
    } seq_state_t;

    seq_state_t st_d;
    seq_state_t st_q;

    logic [IDX_W-1:0] pos;
    logic [KEY_W-1:0] want;
    logic             match;
    logic             ok_next;

    always_comb begin
        st_d    = st_q;
        // A press in the show phase opens a fresh entry at position 0
        pos     = (st_q.phase == PH_SHOW) ? '0 : st_q.idx;
        want    = CODE[pos*KEY_W +: KEY_W];
        match   = single_i && (digit_i == want);
        ok_next = ((pos == '0) ? 1'b1 : st_q.ok) & match;

        if (press_i) begin
            st_d.ok = ok_next;
            if (pos == LAST_IDX) begin
                st_d.phase   = PH_SHOW;
                st_d.idx     = '0;
                st_d.verdict = ok_next ? VERD_OPEN : VERD_ERR;
            end else begin
                st_d.phase   = PH_COLLECT;
                st_d.idx     = pos + IDX_W'(1);
                st_d.verdict = VERD_NONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) begin
            st_q.phase   <= PH_COLLECT;
            st_q.idx     <= '0;
            st_q.ok      <= 1'b0;
            st_q.verdict <= VERD_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign verdict_o = st_q.verdict;

endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import lock_pkg::*;
#(
    parameter int unsigned                    NUM_KEYS = DEF_NUM_KEYS,
    parameter int unsigned                    CODE_LEN = DEF_CODE_LEN,
    parameter int unsigned                    KEY_W    = DEF_KEY_W,
    parameter logic [CODE_LEN*KEY_W-1:0]      CODE     = DEF_CODE
) (
    input  logic                clk_i,
    input  logic                clr_ni,
    input  logic [NUM_KEYS-1:0] key_i,
    output logic [1:0]          verdict_o
);

    logic [NUM_KEYS-1:0] rise;
    logic                press;
    logic                single;
    logic [KEY_W-1:0]    digit;

    lock_edge_detect #(
        .WIDTH (NUM_KEYS)
    ) u_edge (
        .clk_i  (clk_i),
        .clr_ni (clr_ni),
        .lvl_i  (key_i),
        .rise_o (rise)
    );

    lock_key_decode #(
        .NUM_KEYS (NUM_KEYS),
        .KEY_W    (KEY_W)
    ) u_decode (
        .rise_i   (rise),
        .press_o  (press),
        .single_o (single),
        .digit_o  (digit)
    );

    lock_seq_fsm #(
        .CODE_LEN (CODE_LEN),
        .KEY_W    (KEY_W),
        .CODE     (CODE)
    ) u_fsm (
        .clk_i     (clk_i),
        .clr_ni    (clr_ni),
        .press_i   (press),
        .single_i  (single),
        .digit_i   (digit),
        .verdict_o (verdict_o)
    );

endmodule

// File: rtl/combo_lock_checker.sv
module combo_lock_checker #(
    parameter int unsigned NUM_KEYS = 4
) (
    input logic                clk_i,
    input logic                clr_ni,
    input logic [NUM_KEYS-1:0] key_i,
    input logic [1:0]          verdict_o
);

    AST_CLEAR_QUIET: assert property (@(posedge clk_i)
        !clr_ni |-> verdict_o == 2'b00); // R1

    AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!clr_ni)
        ((key_i & ~$past(key_i)) == '0) |=> $stable(verdict_o)); // R2

    AST_NEW_ENTRY_CLEARS: assert property (@(posedge clk_i) disable iff (!clr_ni)
        (verdict_o != 2'b00 && (key_i & ~$past(key_i)) != '0) |=> verdict_o == 2'b00); // R7

    AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!clr_ni)
        $onehot0(verdict_o)); // R9

endmodule

bind combo_lock combo_lock_checker #(
    .NUM_KEYS (NUM_KEYS)
) u_chk (
    .clk_i     (clk_i),
    .clr_ni    (clr_ni),
    .key_i     (key_i),
    .verdict_o (verdict_o)
);

// File: tb/sim_combo_lock.sv
module sim_combo_lock;

    logic       clk_i = 1'b0;
    logic       clr_ni = 1'b0;
    logic [3:0] key_i = 4'b0000;
    logic [1:0] verdict_o;

    int total = 0;
    int bad   = 0;

    // Reference model state
    logic [3:0] m_prev  = 4'b1111;
    int         m_cnt   = 0;
    logic       m_ok    = 1'b0;
    logic       m_shown = 1'b0;
    logic [1:0] m_verd  = 2'b00;

    always #4 clk_i = ~clk_i;   // 125 MHz

    combo_lock u0 (
        .clk_i     (clk_i),
        .clr_ni    (clr_ni),
        .key_i     (key_i),
        .verdict_o (verdict_o)
    );

    function automatic logic [1:0] code_digit(int p);
        case (p)
            0: return 2'd0;
            1: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic bit one_hot4(logic [3:0] v);
        return (v == 4'b0001) || (v == 4'b0010) || (v == 4'b0100) || (v == 4'b1000);
    endfunction

    task automatic model_reset();
        m_prev  = 4'b1111;
        m_cnt   = 0;
        m_ok    = 1'b0;
        m_shown = 1'b0;
        m_verd  = 2'b00;
    endtask

    task automatic model_step(logic [3:0] k);
        logic [3:0] r;
        logic       hit;
        r = k & ~m_prev;
        m_prev = k;
        if (r != 4'b0000) begin
            if (m_shown) begin
                m_shown = 1'b0;
                m_cnt   = 0;
            end
            hit  = one_hot4(r) && r[code_digit(m_cnt)];
            m_ok = (m_cnt == 0) ? hit : (m_ok && hit);
            m_cnt++;
            if (m_cnt == 3) begin
                m_verd  = m_ok ? 2'b01 : 2'b10;
                m_shown = 1'b1;
                m_cnt   = 0;
            end else begin
                m_verd = 2'b00;
            end
        end
    endtask

    task automatic check(string tag);
        total++;
        if (verdict_o !== m_verd || verdict_o === 2'b11) begin
            bad++;
            $display("FAIL %s: verdict actual=%b expected=%b", tag, verdict_o, m_verd);
        end
    endtask

    // Drive at negedge, let one posedge act, sample at the following negedge
    task automatic step(logic [3:0] k, string tag);
        key_i = k;
        model_step(k);
        @(posedge clk_i);
        @(negedge clk_i);
        check(tag);
    endtask

    task automatic do_clear(logic [3:0] k);
        clr_ni = 1'b0;
        key_i  = k;
        model_reset();
        @(negedge clk_i);
        check("R1 during clear");
        @(negedge clk_i);
        clr_ni = 1'b1;
        model_prev_keep(k);
    endtask

    task automatic model_prev_keep(logic [3:0] k);
        m_prev = m_prev & 4'b1111;
        if (k == 4'b0000) m_prev = 4'b1111;
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk_i);
        do_clear(4'b0000);
        step(4'b0000, "R1 idle after clear");

        // Correct code
        step(4'b0001, "R5 first digit quiet");
        step(4'b0000, "R5 release");
        step(4'b0100, "R5 second digit quiet");
        step(4'b0000, "R5 release");
        step(4'b1000, "R3 correct code opens");
        // Hold key: verdict held, no new press
        for (int i = 0; i < 4; i++) step(4'b1000, "R2 R7 hold keeps verdict");
        step(4'b0000, "R7 release keeps verdict");
        // Back-to-back new entry: first press clears and counts
        step(4'b0001, "R7 new press clears verdict");
        step(4'b0000, "R7 release");
        step(4'b0100, "R7 second digit");
        step(4'b0000, "R7 release");
        step(4'b1000, "R7 new entry opens");
        step(4'b0000, "R7 release");

        // Wrong first digit: no early fail
        step(4'b0010, "R5 wrong first quiet");
        step(4'b0000, "R5 release");
        step(4'b0100, "R5 second quiet after wrong");
        step(4'b0000, "R5 release");
        step(4'b1000, "R4 wrong code errors");
        step(4'b0000, "R4 release");

        // Long hold mid-entry counts once
        step(4'b0001, "R2 press digit0");
        for (int i = 0; i < 5; i++) step(4'b0001, "R2 hold digit0");
        step(4'b0000, "R2 release");
        step(4'b0100, "R2 digit2");
        step(4'b0100, "R2 hold digit2");
        step(4'b0000, "R2 release");
        step(4'b1000, "R2 held presses counted once");
        step(4'b0000, "R2 release");

        // Two keys rising together count as one wrong press
        step(4'b0101, "R6 double rise first");
        step(4'b0000, "R6 release");
        step(4'b0100, "R6 second quiet");
        step(4'b0000, "R6 release");
        step(4'b1000, "R6 double rise gives error");
        step(4'b0000, "R6 release");
        step(4'b0001, "R6 digit0");
        step(4'b0000, "R6 release");
        step(4'b1100, "R6 double rise mid entry");
        step(4'b0000, "R6 release");
        step(4'b1000, "R6 mid entry error");
        step(4'b0000, "R6 release");

        // Key held through clear release is not a press
        @(negedge clk_i);
        do_clear(4'b0001);
        step(4'b0001, "R8 held key not counted");
        step(4'b0000, "R8 release");
        step(4'b0100, "R8 first counted press");
        step(4'b0000, "R8 release");
        step(4'b1000, "R8 only two presses so far");
        step(4'b0000, "R8 release");
        step(4'b0001, "R8 third press errors");
        step(4'b0000, "R8 release");

        // Constrained random
        for (int n = 0; n < 3000; n++) begin
            int unsigned sel;
            logic [3:0]  k;
            sel = $urandom_range(99);
            if (sel < 45)      k = 4'b0000;
            else if (sel < 65) k = key_i;
            else if (sel < 92) k = 4'b0001 << $urandom_range(3);
            else               k = 4'($urandom_range(15));
            step(k, "R3 R4 R6 R9 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule